// File: doc/BRIEF.md
# Data Access Routing Unit

This block sits behind the address translation and cache tag lookups of a processor's data side. For every data access it receives the lookup results (read-buffer, main data cache, mini data cache and instruction cache hits), the page attributes (cacheable and bufferable), the enables of the translation unit, the data cache and the write buffer, and both the virtual and physical addresses. It decides where the access is serviced and emits that decision as a one-hot command, one cycle after it accepts the request.

Reads consult their hit sources in a fixed priority. Misses are sent to a line fill in one of the two data caches, selected by the bufferable flag, or to an uncached bus access. A reserved physical window turns a read miss into a cache soft-flush instead of an access. Writes that miss the data caches go to the write buffer or to the bus. Accesses that must not overtake buffered writes first raise a drain command. The block then holds a busy output until a drain-done input arrives, and only after that issues the access itself.

Top module: `access_router`

## Requirements
- R1: After reset `cmd` is all zero and `busy` is low. `cmd` never has more than one bit set. Its bits are: 0 serve from read buffer, 1 serve/update main cache, 2 serve/update mini cache, 3 allocate main line, 4 allocate mini line, 5 post to write buffer, 6 drain write buffer, 7 uncached bus access, 8 soft-flush main cache, 9 soft-flush mini cache, 10 discard (complete with no data), 11 return stored fault.
- R2: With translation on, a read uses the first hit in the order read buffer (bit 0), main cache (bit 1), mini cache (bit 2).
- R3: A read that hits the read buffer while `rbuf_fault` is high produces the fault command (bit 11) instead of data.
- R4: A read that misses all three sources, with a physical address in [WIN_LO, WIN_HI), soft-flushes the main cache (bit 8) when cacheable and bufferable. It soft-flushes the mini cache (bit 9) when cacheable and not bufferable, and gives discard (bit 10) when not cacheable. It never drains.
- R5: A read miss outside the window on a bufferable page first drains (bit 6). It then allocates a main-cache line (bit 3) when the page is cacheable and the data cache is enabled, and otherwise issues a bus access (bit 7).
- R6: A read miss outside the window on a non-bufferable page allocates a mini-cache line (bit 4) when cacheable with the data cache enabled, and otherwise issues a bus access, without draining.
- R7: With translation on, a write that hits the main cache updates it (bit 1), else one that hits the mini cache updates that (bit 2). The read buffer plays no part in writes.
- R8: A write that misses both data caches posts to the write buffer (bit 5) when bufferable with the buffer enabled. It goes to the bus when bufferable with the buffer disabled. When not bufferable it drains first and then goes to the bus.
- R9: `icache_upd` pulses together with the first command of any accepted write that hits the instruction cache, whether translation is on or off.
- R10: With translation off, every access becomes a bus access at the virtual address without draining. With translation on, `cmd_addr` carries the physical address.
- R11: In a drain sequence, the drain command appears for exactly one cycle and `busy` is high from that cycle on. `busy` stays high until `drain_done` is sampled high, and the deferred access command appears in the cycle after that, with `busy` low. Requests presented while `busy` is high are ignored.
- R12: A request accepted at a clock edge produces its command in the cycle following that edge. `cmd` is zero in every cycle that follows an edge with no acceptance and no drain completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present (taken when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| xlat_on | input | 1 | Address translation enabled |
| pg_cacheable | input | 1 | Page cacheable attribute |
| pg_bufferable | input | 1 | Page bufferable attribute |
| dcache_en | input | 1 | Data cache enabled |
| wbuf_en | input | 1 | Write buffer enabled |
| rbuf_hit | input | 1 | Read buffer hit |
| rbuf_fault | input | 1 | Hit read-buffer entry holds a fault |
| main_hit | input | 1 | Main data cache hit |
| mini_hit | input | 1 | Mini data cache hit |
| icache_hit | input | 1 | Instruction cache hit |
| virt_addr | input | ADDR_W | Virtual address |
| phys_addr | input | ADDR_W | Physical address |
| drain_done | input | 1 | Write buffer has finished draining |
| cmd | output | 12 | One-hot routing command |
| cmd_addr | output | ADDR_W | Address belonging to the command |
| icache_upd | output | 1 | Update the instruction cache with this write |
| busy | output | 1 | Waiting for a drain to finish |

## Verification
The bench builds the block with its default parameters: a 32-bit address and the window from 0xE0000000 up to 0xE8000000. Directed requests place physical addresses on both sides of each window edge, so the inclusive lower bound and exclusive upper bound are exercised. They also walk every hit combination and page-attribute combination for reads and writes. A randomized phase mixes requests offered during busy periods with drain-done arriving in the same cycle as the drain command or many cycles later.

// File: rtl/router_pkg.sv
package router_pkg;

  localparam int CMD_W = 12;

  localparam int C_SRV_RBUF   = 0;
  localparam int C_SRV_MAIN   = 1;
  localparam int C_SRV_MINI   = 2;
  localparam int C_ALLOC_MAIN = 3;
  localparam int C_ALLOC_MINI = 4;
  localparam int C_POST_WBUF  = 5;
  localparam int C_DRAIN      = 6;
  localparam int C_BUS        = 7;
  localparam int C_FLUSH_MAIN = 8;
  localparam int C_FLUSH_MINI = 9;
  localparam int C_DISCARD    = 10;
  localparam int C_FAULT      = 11;

  typedef logic [CMD_W-1:0] cmd_t;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;

  function automatic cmd_t onehot_cmd(input int idx);
    return cmd_t'(1) << idx;
  endfunction

  // Half-open window compare on zero-extended addresses.
  function automatic logic addr_in_window(input logic [63:0] a,
                                          input logic [63:0] lo,
                                          input logic [63:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  // Line target chosen by the bufferable flag.
  function automatic int fill_target(input logic bufferable);
    return bufferable ? C_ALLOC_MAIN : C_ALLOC_MINI;
  endfunction

  function automatic int flush_target(input logic bufferable);
    return bufferable ? C_FLUSH_MAIN : C_FLUSH_MINI;
  endfunction

endpackage

// File: rtl/rt_window.sv
module rt_window #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_LO = ADDR_W'(32'hE000_0000),
  parameter logic [ADDR_W-1:0] WIN_HI = ADDR_W'(32'hE800_0000)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);
  import router_pkg::*;

  localparam logic [63:0] LO_EXT = 64'(WIN_LO);
  localparam logic [63:0] HI_EXT = 64'(WIN_HI);

  assign in_win = addr_in_window(64'(addr), LO_EXT, HI_EXT);

endmodule

// File: rtl/rt_decide.sv
module rt_decide #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_LO = ADDR_W'(32'hE000_0000),
  parameter logic [ADDR_W-1:0] WIN_HI = ADDR_W'(32'hE800_0000)
) (
  input  logic                   req_write,
  input  logic                   xlat_on,
  input  logic                   pg_cacheable,
  input  logic                   pg_bufferable,
  input  logic                   dcache_en,
  input  logic                   wbuf_en,
  input  logic                   rbuf_hit,
  input  logic                   rbuf_fault,
  input  logic                   main_hit,
  input  logic                   mini_hit,
  input  logic                   icache_hit,
  input  logic [ADDR_W-1:0]      virt_addr,
  input  logic [ADDR_W-1:0]      phys_addr,
  output router_pkg::cmd_t       fin_cmd,
  output logic                   need_drain,
  output logic [ADDR_W-1:0]      route_addr,
  output logic                   ic_update
);
  import router_pkg::*;

  logic in_win;
  logic fill_ok;

  rt_window #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
    .addr   (phys_addr),
    .in_win (in_win)
  );

  assign fill_ok    = pg_cacheable && dcache_en;
  assign route_addr = xlat_on ? phys_addr : virt_addr;
  assign ic_update  = req_write && icache_hit;

  always_comb begin
    fin_cmd    = onehot_cmd(C_BUS);
    need_drain = 1'b0;
    if (!xlat_on) begin
      fin_cmd = onehot_cmd(C_BUS);
    end else if (!req_write) begin
      if (rbuf_hit) begin
        fin_cmd = rbuf_fault ? onehot_cmd(C_FAULT) : onehot_cmd(C_SRV_RBUF);
      end else if (main_hit) begin
        fin_cmd = onehot_cmd(C_SRV_MAIN);
      end else if (mini_hit) begin
        fin_cmd = onehot_cmd(C_SRV_MINI);
      end else if (in_win) begin
        fin_cmd = pg_cacheable ? onehot_cmd(flush_target(pg_bufferable))
                               : onehot_cmd(C_DISCARD);
      end else begin
        need_drain = pg_bufferable;
        fin_cmd    = fill_ok ? onehot_cmd(fill_target(pg_bufferable))
                             : onehot_cmd(C_BUS);
      end
    end else begin
      if (main_hit) begin
        fin_cmd = onehot_cmd(C_SRV_MAIN);
      end else if (mini_hit) begin
        fin_cmd = onehot_cmd(C_SRV_MINI);
      end else if (pg_bufferable) begin
        fin_cmd = wbuf_en ? onehot_cmd(C_POST_WBUF) : onehot_cmd(C_BUS);
      end else begin
        need_drain = 1'b1;
        fin_cmd    = onehot_cmd(C_BUS);
      end
    end
  end

endmodule

// File: rtl/rt_drain_seq.sv
module rt_drain_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  router_pkg::cmd_t  fin_cmd,
  input  logic              need_drain,
  input  logic [ADDR_W-1:0] route_addr,
  input  logic              ic_update,
  input  logic              drain_done,
  output router_pkg::cmd_t  cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              icupd_q,
  output logic              busy,
  output logic              ev_accept,
  output logic              ev_drain_start,
  output logic              ev_release
);
  import router_pkg::*;

  seq_state_e state;
  cmd_t       pend_cmd;

  assign busy           = (state == SEQ_WAIT);
  assign ev_accept      = req_valid && !busy;
  assign ev_drain_start = ev_accept && need_drain;
  assign ev_release     = busy && drain_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      pend_cmd <= '0;
      cmd_q    <= '0;
      addr_q   <= '0;
      icupd_q  <= 1'b0;
    end else begin
      icupd_q <= ev_accept && ic_update;
      if (ev_accept) begin
        addr_q <= route_addr;
      end
      if (ev_drain_start) begin
        cmd_q    <= onehot_cmd(C_DRAIN);
        pend_cmd <= fin_cmd;
        state    <= SEQ_WAIT;
      end else if (ev_accept) begin
        cmd_q <= fin_cmd;
      end else if (ev_release) begin
        cmd_q <= pend_cmd;
        state <= SEQ_IDLE;
      end else begin
        cmd_q <= '0;
      end
    end
  end

endmodule

// File: rtl/access_router.sv
module access_router #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_LO = ADDR_W'(32'hE000_0000),
  parameter logic [ADDR_W-1:0] WIN_HI = ADDR_W'(32'hE800_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              xlat_on,
  input  logic              pg_cacheable,
  input  logic              pg_bufferable,
  input  logic              dcache_en,
  input  logic              wbuf_en,
  input  logic              rbuf_hit,
  input  logic              rbuf_fault,
  input  logic              main_hit,
  input  logic              mini_hit,
  input  logic              icache_hit,
  input  logic [ADDR_W-1:0] virt_addr,
  input  logic [ADDR_W-1:0] phys_addr,
  input  logic              drain_done,
  output logic [11:0]       cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              icache_upd,
  output logic              busy
);
  import router_pkg::*;

  cmd_t              fin_cmd;
  cmd_t              cmd_q;
  logic              need_drain;
  logic [ADDR_W-1:0] route_addr;
  logic              ic_update;
  logic              ev_accept;
  logic              ev_drain_start;
  logic              ev_release;

  rt_decide #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_decide (
    .req_write     (req_write),
    .xlat_on       (xlat_on),
    .pg_cacheable  (pg_cacheable),
    .pg_bufferable (pg_bufferable),
    .dcache_en     (dcache_en),
    .wbuf_en       (wbuf_en),
    .rbuf_hit      (rbuf_hit),
    .rbuf_fault    (rbuf_fault),
    .main_hit      (main_hit),
    .mini_hit      (mini_hit),
    .icache_hit    (icache_hit),
    .virt_addr     (virt_addr),
    .phys_addr     (phys_addr),
    .fin_cmd       (fin_cmd),
    .need_drain    (need_drain),
    .route_addr    (route_addr),
    .ic_update     (ic_update)
  );

  rt_drain_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .fin_cmd        (fin_cmd),
    .need_drain     (need_drain),
    .route_addr     (route_addr),
    .ic_update      (ic_update),
    .drain_done     (drain_done),
    .cmd_q          (cmd_q),
    .addr_q         (cmd_addr),
    .icupd_q        (icache_upd),
    .busy           (busy),
    .ev_accept      (ev_accept),
    .ev_drain_start (ev_drain_start),
    .ev_release     (ev_release)
  );

  assign cmd = cmd_q;

endmodule

// File: rtl/router_chk.sv
module router_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              xlat_on,
  input logic              rbuf_hit,
  input logic              rbuf_fault,
  input logic              icache_hit,
  input logic [ADDR_W-1:0] virt_addr,
  input logic              drain_done,
  input logic [11:0]       cmd,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              icache_upd,
  input logic              busy
);
  import router_pkg::*;

  localparam cmd_t DRAIN_MASK = cmd_t'(1) << C_DRAIN;

  logic live;
  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd));

  p_quiet_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((cmd & ~DRAIN_MASK) == '0));

  p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !drain_done) |=> busy);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && drain_done) |=> (!busy && (cmd[C_BUS] || cmd[C_ALLOC_MAIN])));

  p_drain_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[C_DRAIN] |-> busy);

  p_xlat_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(req_valid && !busy && !xlat_on))
      |-> (cmd[C_BUS] && cmd_addr == $past(virt_addr)));

  p_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(req_valid && !busy && xlat_on && !req_write && rbuf_hit && rbuf_fault))
      |-> cmd[C_FAULT]);

  p_icache_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(req_valid && !busy && req_write && icache_hit)) |-> icache_upd);

endmodule

bind access_router router_chk #(.ADDR_W(ADDR_W)) u_router_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .xlat_on    (xlat_on),
  .rbuf_hit   (rbuf_hit),
  .rbuf_fault (rbuf_fault),
  .icache_hit (icache_hit),
  .virt_addr  (virt_addr),
  .drain_done (drain_done),
  .cmd        (cmd),
  .cmd_addr   (cmd_addr),
  .icache_upd (icache_upd),
  .busy       (busy)
);

// File: tb/test_access_router.sv
module test_access_router;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, xlat_on = 0, pg_c = 0, pg_b = 0;
  logic dc_en = 0, wb_en = 0, rb_hit = 0, rb_flt = 0, mn_hit = 0, mi_hit = 0, ic_hit = 0;
  logic [AW-1:0] va = '0, pa = '0;
  logic drain_done = 0;
  logic [11:0] cmd;
  logic [AW-1:0] cmd_addr;
  logic icache_upd, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  access_router i_access_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .xlat_on(xlat_on), .pg_cacheable(pg_c), .pg_bufferable(pg_b),
    .dcache_en(dc_en), .wbuf_en(wb_en), .rbuf_hit(rb_hit), .rbuf_fault(rb_flt),
    .main_hit(mn_hit), .mini_hit(mi_hit), .icache_hit(ic_hit),
    .virt_addr(va), .phys_addr(pa), .drain_done(drain_done),
    .cmd(cmd), .cmd_addr(cmd_addr), .icache_upd(icache_upd), .busy(busy)
  );

  int n_vec = 0, n_bad = 0;
  string cur_tag = "R1";

  // Reference model: command index names
  // 0 rbuf,1 main,2 mini,3 alloc main,4 alloc mini,5 post,6 drain,7 bus,
  // 8 flush main,9 flush mini,10 discard,11 fault
  bit          m_wait = 0;
  logic [11:0] m_cmd = '0;
  int          m_pend [$];
  logic [AW-1:0] m_addr = '0;
  bit          m_ic = 0;

  function automatic void plan(output int code, output bit dr);
    bit win;
    dr = 0;
    win = (pa >= 32'hE000_0000) && (pa <= 32'hE7FF_FFFF);
    if (!xlat_on) code = 7;
    else if (req_write) begin
      case (1'b1)
        mn_hit: code = 1;
        mi_hit: code = 2;
        pg_b:   code = wb_en ? 5 : 7;
        default: begin code = 7; dr = 1; end
      endcase
    end else begin
      case (1'b1)
        rb_hit: code = rb_flt ? 11 : 0;
        mn_hit: code = 1;
        mi_hit: code = 2;
        win:    code = !pg_c ? 10 : (pg_b ? 8 : 9);
        default: begin
          dr = pg_b;
          if (pg_c && dc_en) code = pg_b ? 3 : 4;
          else code = 7;
        end
      endcase
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wait = 0; m_cmd = '0; m_addr = '0; m_ic = 0; m_pend.delete();
    end else begin
      m_ic = 0;
      if (!m_wait && req_valid) begin
        int code; bit dr;
        plan(code, dr);
        m_addr = xlat_on ? pa : va;
        m_ic = req_write && ic_hit;
        if (dr) begin m_cmd = 12'd1 << 6; m_pend.push_back(code); m_wait = 1; end
        else m_cmd = 12'd1 << code;
      end else if (m_wait && drain_done) begin
        m_cmd = 12'd1 << m_pend.pop_front();
        m_wait = 0;
      end else m_cmd = '0;
    end
  end

  function automatic string tag_of(logic [11:0] c);
    if (c[11]) return "R3";
    if (c[0] || c[1] || c[2]) return "R2 or R7";
    if (c[8] || c[9] || c[10]) return "R4";
    if (c[3] || c[6]) return "R5";
    if (c[4]) return "R6";
    if (c[5]) return "R8";
    if (c[7]) return "R8 or R10";
    return "R12";
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    n_vec++;
    if (cmd !== m_cmd) begin
      n_bad++;
      $display("FAIL %s/%s cmd actual=%03h expected=%03h", cur_tag, tag_of(m_cmd), cmd, m_cmd);
    end
    if (busy !== m_wait) begin
      n_bad++;
      $display("FAIL %s/R11 busy actual=%0b expected=%0b", cur_tag, busy, m_wait);
    end
    if (icache_upd !== m_ic) begin
      n_bad++;
      $display("FAIL %s/R9 icache_upd actual=%0b expected=%0b", cur_tag, icache_upd, m_ic);
    end
    if (cmd_addr !== m_addr) begin
      n_bad++;
      $display("FAIL %s/R10 cmd_addr actual=%08h expected=%08h", cur_tag, cmd_addr, m_addr);
    end
  end

  task automatic idle_until_free(input int delay);
    req_valid = 0;
    for (int i = 0; i < delay; i++) @(negedge clk);
    drain_done = 1;
    @(negedge clk);
    drain_done = 0;
    @(negedge clk);
  endtask

  task automatic issue(input string tag, input bit wr, input bit xl, input bit c,
                       input bit b, input bit dce, input bit wbe, input bit rh,
                       input bit rf, input bit mh, input bit nh, input bit ih,
                       input logic [AW-1:0] p);
    cur_tag = tag;
    req_valid = 1; req_write = wr; xlat_on = xl; pg_c = c; pg_b = b;
    dc_en = dce; wb_en = wbe; rb_hit = rh; rb_flt = rf; mn_hit = mh;
    mi_hit = nh; ic_hit = ih; pa = p; va = p ^ 32'h0F0F_0000;
    @(negedge clk);
    idle_until_free(3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_tag = "R1";
    repeat (2) @(negedge clk);
    // R2 priority
    issue("R2", 0,1,1,1,1,1, 1,0,1,1,0, 32'h1000_0000);
    issue("R2", 0,1,1,1,1,1, 0,0,1,1,0, 32'h1000_0004);
    issue("R2", 0,1,1,1,1,1, 0,0,0,1,0, 32'h1000_0008);
    // R3 fault
    issue("R3", 0,1,1,1,1,1, 1,1,1,0,0, 32'h1000_000C);
    // R4 window edges
    issue("R4", 0,1,1,1,1,1, 0,0,0,0,0, 32'hE000_0000);
    issue("R4", 0,1,1,0,1,1, 0,0,0,0,0, 32'hE7FF_FFFC);
    issue("R4", 0,1,0,1,1,1, 0,0,0,0,0, 32'hE400_0000);
    issue("R5", 0,1,1,1,1,1, 0,0,0,0,0, 32'hE800_0000);
    issue("R6", 0,1,1,0,1,1, 0,0,0,0,0, 32'hDFFF_FFFC);
    // R5 drain then fill/bus
    issue("R5", 0,1,0,1,1,1, 0,0,0,0,0, 32'h2000_0000);
    issue("R5", 0,1,1,1,0,1, 0,0,0,0,0, 32'h2000_0010);
    // R6
    issue("R6", 0,1,1,0,0,1, 0,0,0,0,0, 32'h3000_0000);
    issue("R6", 0,1,0,0,1,1, 0,0,0,0,0, 32'h3000_0004);
    // R7 write hits; read buffer ignored for writes
    issue("R7", 1,1,1,1,1,1, 1,0,1,1,0, 32'h4000_0000);
    issue("R7", 1,1,1,1,1,1, 1,1,0,1,0, 32'h4000_0004);
    // R8 write misses
    issue("R8", 1,1,1,1,1,1, 0,0,0,0,0, 32'h5000_0000);
    issue("R8", 1,1,1,1,1,0, 0,0,0,0,0, 32'h5000_0004);
    issue("R8", 1,1,1,0,1,1, 0,0,0,0,0, 32'h5000_0008);
    // R9 icache update with translation on and off
    issue("R9", 1,1,0,0,1,1, 0,0,0,0,1, 32'h6000_0000);
    issue("R9", 1,0,0,0,1,1, 0,0,0,0,1, 32'h6000_0004);
    // R10 translation off: bus at virtual address, even on hits
    issue("R10", 0,0,1,1,1,1, 1,1,1,1,0, 32'hE000_0000);
    issue("R10", 1,0,1,0,1,1, 0,0,0,0,0, 32'h7000_0000);
    // R11 requests held while busy are ignored; long drain
    cur_tag = "R11";
    req_valid = 1; req_write = 1; xlat_on = 1; pg_b = 0; mn_hit = 0; mi_hit = 0;
    ic_hit = 1; pa = 32'h7100_0000; va = 32'h0;
    @(negedge clk);
    pa = 32'h7200_0000; ic_hit = 0;
    repeat (6) @(negedge clk);
    req_valid = 0;
    idle_until_free(0);
    // R12 back-to-back acceptance with no drain
    cur_tag = "R12";
    req_valid = 1; req_write = 0; pg_b = 0; pg_c = 0; pa = 32'h7300_0000;
    repeat (4) @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    // randomized mix
    cur_tag = "RND";
    for (int i = 0; i < 4000; i++) begin
      int sel;
      req_valid = ($urandom_range(0, 3) != 0);
      req_write = $urandom_range(0, 1); xlat_on = ($urandom_range(0, 7) != 0);
      pg_c = $urandom_range(0, 1); pg_b = $urandom_range(0, 1);
      dc_en = $urandom_range(0, 1); wb_en = $urandom_range(0, 1);
      rb_hit = ($urandom_range(0, 3) == 0); rb_flt = $urandom_range(0, 1);
      mn_hit = ($urandom_range(0, 3) == 0); mi_hit = ($urandom_range(0, 3) == 0);
      ic_hit = $urandom_range(0, 1); drain_done = ($urandom_range(0, 2) == 0);
      sel = $urandom_range(0, 4);
      case (sel)
        0: pa = 32'hE000_0000;
        1: pa = 32'hE7FF_FFFF;
        2: pa = 32'hE800_0000;
        3: pa = 32'hDFFF_FFFF;
        default: pa = $urandom;
      endcase
      va = $urandom;
      @(negedge clk);
    end
    req_valid = 0;
    idle_until_free(1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule